// File: doc/BRIEF.md
# Fine Pixel Panning Shifter

This block sits in the pixel path of a raster display controller, between the memory fetch and the colour lookup. Upstream logic delivers parallel words of pixel lanes. The block drops a programmed number of leading lanes at the start of each scan line and then emits the remaining lanes as a serial pixel stream, one output pixel per clock. The result is a horizontal pan with a resolution finer than one memory word. The fine count is interpreted according to the pixel mode: plain 8-dot, 9-dot character cells, or paired-lane pixels where two 4-bit lanes form one wide pixel. A coarse word pan adds whole words to the discard.

A split-line strobe marks the scan line at which a lower, fixed screen region begins. When the split-pan mode bit is set, every line that starts at or after that strobe uses a pan of zero, until the next frame start. When the bit is clear, the split has no effect on panning.

The controller is a small state machine. `ST_IDLE` is entered at reset and on `frame_start`, and fetched words are ignored there. `line_start` moves any state to `ST_SKIP`, where arriving lanes are discarded until the sampled skip count is used up. `ST_SKIP` moves to `ST_STREAM` once the remaining skip reaches zero. `ST_STREAM` emits a pixel whenever enough lanes are buffered, and it holds until the next `line_start` or `frame_start`.

Top module: `fine_pan_shifter`

## Requirements
- R1: After reset, and after `frame_start` until the next `line_start`, `pix_vld` stays 0, and words offered with `word_vld` in that interval are discarded.
- R2: With `pel_mode` 2'b00 or 2'b11, the first output pixel of a line is the lane at index `fine_cnt[2:0]` plus the coarse offset.
- R3: With `pel_mode` 2'b01, the fine discard is (`fine_cnt`+1) mod 9. So a count of 8 discards nothing and a count of 7 discards 8 lanes.
- R4: With `pel_mode` 2'b10, the fine discard is `fine_cnt` with bit 0 cleared and bit 3 ignored. Each output pixel takes two consecutive lanes, with the earlier lane in `pix[2*PIX_W-1:PIX_W]` and the next lane in `pix[PIX_W-1:0]`.
- R5: `coarse_pan` adds `coarse_pan`*WORD_PIX lanes to the discard of each line.
- R6: The pan values are sampled in the `line_start` cycle. Changes to `fine_cnt`, `coarse_pan` or `pel_mode` during the line do not affect that line.
- R7: With `pan_split_mode`=1, a `split_hit` pulse forces zero fine and coarse pan on every line that starts in the same cycle or later, until `frame_start`.
- R8: With `pan_split_mode`=0, `split_hit` does not change the pan of any line.
- R9: Lane 0 is `word_data[PIX_W-1:0]`. Lanes leave in order without gaps or repeats. In single-lane modes the upper half of `pix` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | Frame boundary strobe, returns to idle and clears the split state |
| line_start | input | 1 | Start of the active part of a scan line, samples the pan values |
| split_hit | input | 1 | Strobe marking the split line |
| pan_split_mode | input | 1 | 1: zero pan below the split; 0: same pan on both regions |
| pel_mode | input | 2 | 00 8-dot, 01 9-dot, 10 paired lanes, 11 as 00 |
| fine_cnt | input | 4 | Fine pan count |
| coarse_pan | input | 2 | Whole-word pan |
| word_vld | input | 1 | A fetched word is present on word_data |
| word_data | input | WORD_PIX*PIX_W | Fetched pixel lanes, lane 0 in the low bits |
| pix_vld | output | 1 | Output pixel valid |
| pix | output | 2*PIX_W | Output pixel |

## Verification
The hardest situation to reach is a split that takes effect on the line starting in the same cycle as the strobe, followed by the return to normal panning at the next frame. The bench builds frames that pulse `split_hit` both between lines and together with `line_start`, in both split-pan modes. Each lane carries its own index, so the first pixels of every line show the exact discard. The sweep covers every mode, fine count and coarse value, and it disturbs the pan inputs in the middle of each line.

// File: rtl/fps_pkg.sv
package fps_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_SKIP   = 2'b01,
        ST_STREAM = 2'b10
    } fps_state_t;

    typedef enum logic [1:0] {
        PM_STD  = 2'b00,
        PM_NINE = 2'b01,
        PM_PAIR = 2'b10,
        PM_ALT  = 2'b11
    } pel_mode_t;

endpackage

// File: rtl/fps_shift_decode.sv
module fps_shift_decode
    import fps_pkg::*;
#(
    parameter int WORD_PIX = 8,
    parameter int SKIP_W   = 6
) (
    input  logic [1:0]        pel_mode,
    input  logic [3:0]        fine_cnt,
    input  logic [1:0]        coarse_pan,
    input  logic              zero_pan,
    output logic [3:0]        fine_eff,
    output logic [SKIP_W-1:0] skip_total,
    output logic              paired
);

    logic [4:0] inc_cnt;
    logic [4:0] nine_cnt;
    logic [3:0] raw_fine;

    always_comb begin
        inc_cnt  = {1'b0, fine_cnt} + 5'd1;
        nine_cnt = (inc_cnt >= 5'd9) ? (inc_cnt - 5'd9) : inc_cnt;
        unique case (pel_mode_t'(pel_mode))
            PM_NINE: raw_fine = nine_cnt[3:0];
            PM_PAIR: raw_fine = {1'b0, fine_cnt[2:1], 1'b0};
            PM_STD,
            PM_ALT:  raw_fine = {1'b0, fine_cnt[2:0]};
            default: raw_fine = 4'd0;
        endcase
        paired = (pel_mode_t'(pel_mode) == PM_PAIR);
        if (zero_pan) begin
            fine_eff   = 4'd0;
            skip_total = '0;
        end else begin
            fine_eff   = raw_fine;
            skip_total = SKIP_W'(raw_fine)
                       + SKIP_W'(coarse_pan) * SKIP_W'(WORD_PIX);
        end
    end

endmodule

// File: rtl/fps_split_track.sv
module fps_split_track (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic split_hit,
    input  logic pan_split_mode,
    output logic split_seen,
    output logic zero_pan
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            split_seen <= 1'b0;
        end else if (split_hit) begin
            split_seen <= 1'b1;
        end else if (frame_start) begin
            split_seen <= 1'b0;
        end
    end

    assign zero_pan = pan_split_mode && (split_seen || split_hit);

endmodule

// File: rtl/fps_lane_buffer.sv
module fps_lane_buffer #(
    parameter int PIX_W    = 4,
    parameter int WORD_PIX = 8,
    parameter int DEPTH    = 3,
    localparam int CAP     = WORD_PIX * DEPTH,
    localparam int CNT_W   = $clog2(CAP + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      flush,
    input  logic                      push,
    input  logic [WORD_PIX*PIX_W-1:0] push_data,
    input  logic [CNT_W-1:0]          drop,
    output logic [PIX_W-1:0]          lane0,
    output logic [PIX_W-1:0]          lane1,
    output logic [CNT_W-1:0]          fill
);

    logic [PIX_W-1:0] mem_q [CAP];
    logic [PIX_W-1:0] mem_d [CAP];
    logic [CNT_W-1:0] fill_q;
    logic [CNT_W-1:0] fill_d;

    always_comb begin
        int drop_i;
        int kept_i;
        int src_i;
        logic fits;
        drop_i = (drop > fill_q) ? int'(fill_q) : int'(drop);
        kept_i = int'(fill_q) - drop_i;
        fits   = (kept_i + WORD_PIX) <= CAP;
        for (int i = 0; i < CAP; i++) begin
            src_i = i + drop_i;
            if (src_i < CAP && src_i < int'(fill_q)) begin
                mem_d[i] = mem_q[src_i];
            end else begin
                mem_d[i] = '0;
            end
            if (push && fits && i >= kept_i && i < kept_i + WORD_PIX) begin
                mem_d[i] = push_data[(i - kept_i)*PIX_W +: PIX_W];
            end
        end
        fill_d = CNT_W'(kept_i + ((push && fits) ? WORD_PIX : 0));
        if (flush) begin
            for (int i = 0; i < CAP; i++) begin
                mem_d[i] = '0;
            end
            fill_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_q <= '0;
            for (int i = 0; i < CAP; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            fill_q <= fill_d;
            for (int i = 0; i < CAP; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign lane0 = mem_q[0];
    assign lane1 = mem_q[1];
    assign fill  = fill_q;

endmodule

// File: rtl/fine_pan_shifter.sv
module fine_pan_shifter
    import fps_pkg::*;
#(
    parameter int PIX_W    = 4,
    parameter int WORD_PIX = 8,
    parameter int DEPTH    = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      frame_start,
    input  logic                      line_start,
    input  logic                      split_hit,
    input  logic                      pan_split_mode,
    input  logic [1:0]                pel_mode,
    input  logic [3:0]                fine_cnt,
    input  logic [1:0]                coarse_pan,
    input  logic                      word_vld,
    input  logic [WORD_PIX*PIX_W-1:0] word_data,
    output logic                      pix_vld,
    output logic [2*PIX_W-1:0]        pix
);

    localparam int CAP    = WORD_PIX * DEPTH;
    localparam int CNT_W  = $clog2(CAP + 1);
    localparam int SKIP_W = $clog2(3*WORD_PIX + 9);

    fps_state_t state_q, state_d;

    logic [SKIP_W-1:0] skip_q;
    logic [3:0]        shift_q;
    logic              paired_q;
    logic              pix_vld_q;
    logic [2*PIX_W-1:0] pix_q;

    logic [3:0]        fine_eff;
    logic [SKIP_W-1:0] skip_total;
    logic              paired;
    logic              split_seen;
    logic              zero_pan;
    logic              flush;
    logic              push;
    logic [CNT_W-1:0]  drop;
    logic [CNT_W-1:0]  fill;
    logic [PIX_W-1:0]  lane0;
    logic [PIX_W-1:0]  lane1;
    logic [CNT_W-1:0]  need;

    fps_split_track u_split (
        .clk            (clk),
        .rst_n          (rst_n),
        .frame_start    (frame_start),
        .split_hit      (split_hit),
        .pan_split_mode (pan_split_mode),
        .split_seen     (split_seen),
        .zero_pan       (zero_pan)
    );

    fps_shift_decode #(
        .WORD_PIX (WORD_PIX),
        .SKIP_W   (SKIP_W)
    ) u_dec (
        .pel_mode   (pel_mode),
        .fine_cnt   (fine_cnt),
        .coarse_pan (coarse_pan),
        .zero_pan   (zero_pan),
        .fine_eff   (fine_eff),
        .skip_total (skip_total),
        .paired     (paired)
    );

    fps_lane_buffer #(
        .PIX_W    (PIX_W),
        .WORD_PIX (WORD_PIX),
        .DEPTH    (DEPTH)
    ) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push      (push),
        .push_data (word_data),
        .drop      (drop),
        .lane0     (lane0),
        .lane1     (lane1),
        .fill      (fill)
    );

    assign flush = frame_start || line_start;
    assign push  = word_vld && (state_q != ST_IDLE) && !flush;
    assign need  = paired_q ? CNT_W'(2) : CNT_W'(1);

    always_comb begin
        drop = '0;
        unique case (state_q)
            ST_SKIP: begin
                if (int'(skip_q) < int'(fill)) begin
                    drop = CNT_W'(skip_q);
                end else begin
                    drop = fill;
                end
            end
            ST_STREAM: begin
                if (fill >= need) begin
                    drop = need;
                end
            end
            ST_IDLE: drop = '0;
            default: drop = '0;
        endcase
    end

    always_comb begin
        state_d = state_q;
        if (frame_start) begin
            state_d = ST_IDLE;
        end else if (line_start) begin
            state_d = ST_SKIP;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_IDLE;
                ST_SKIP:   state_d = (int'(skip_q) == int'(drop)) ? ST_STREAM : ST_SKIP;
                ST_STREAM: state_d = ST_STREAM;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            skip_q    <= '0;
            shift_q   <= '0;
            paired_q  <= 1'b0;
            pix_vld_q <= 1'b0;
            pix_q     <= '0;
        end else if (frame_start) begin
            pix_vld_q <= 1'b0;
            pix_q     <= '0;
        end else if (line_start) begin
            skip_q    <= skip_total;
            shift_q   <= fine_eff;
            paired_q  <= paired;
            pix_vld_q <= 1'b0;
            pix_q     <= '0;
        end else begin
            unique case (state_q)
                ST_SKIP: begin
                    skip_q    <= skip_q - SKIP_W'(drop);
                    pix_vld_q <= 1'b0;
                end
                ST_STREAM: begin
                    pix_vld_q <= (drop != '0);
                    if (drop != '0) begin
                        pix_q <= paired_q ? {lane0, lane1} : {{PIX_W{1'b0}}, lane0};
                    end
                end
                ST_IDLE: pix_vld_q <= 1'b0;
                default: pix_vld_q <= 1'b0;
            endcase
        end
    end

    assign pix_vld = pix_vld_q;
    assign pix     = pix_q;

endmodule

// File: rtl/fps_checker.sv
module fps_checker
    import fps_pkg::*;
#(
    parameter int CNT_W    = 5,
    parameter int SKIP_W   = 6,
    parameter int CAP      = 24,
    parameter int WORD_PIX = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_start,
    input logic              line_start,
    input logic              split_hit,
    input logic              pan_split_mode,
    input logic [1:0]        pel_mode,
    input logic [3:0]        fine_cnt,
    input logic              word_vld,
    input logic              pix_vld,
    input logic              split_seen,
    input logic [3:0]        shift_q,
    input logic [SKIP_W-1:0] skip_q,
    input logic [CNT_W-1:0]  fill,
    input fps_state_t        state_q
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !pix_vld); // R1

    AST_LINE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> !pix_vld); // R1

    AST_STD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && !frame_start && pel_mode == 2'b00) |=> (shift_q < 4'd8)); // R2

    AST_NINE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && !frame_start && pel_mode == 2'b01 && fine_cnt == 4'd8)
        |=> (shift_q == 4'd0)); // R3

    AST_PAIR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && !frame_start && pel_mode == 2'b10) |=> !shift_q[0]); // R4

    AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !line_start |=> $stable(shift_q)); // R6

    AST_SPLIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && !frame_start && pan_split_mode && (split_seen || split_hit))
        |=> (skip_q == '0 && shift_q == 4'd0)); // R7

    AST_ROOM_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && state_q == ST_STREAM) |-> (int'(fill) <= CAP - WORD_PIX)); // R9

endmodule

bind fine_pan_shifter fps_checker #(
    .CNT_W    (CNT_W),
    .SKIP_W   (SKIP_W),
    .CAP      (CAP),
    .WORD_PIX (WORD_PIX)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .frame_start    (frame_start),
    .line_start     (line_start),
    .split_hit      (split_hit),
    .pan_split_mode (pan_split_mode),
    .pel_mode       (pel_mode),
    .fine_cnt       (fine_cnt),
    .word_vld       (word_vld),
    .pix_vld        (pix_vld),
    .split_seen     (split_seen),
    .shift_q        (shift_q),
    .skip_q         (skip_q),
    .fill           (fill),
    .state_q        (state_q)
);

// File: tb/sim_fine_pan_shifter.sv
`timescale 1ns/100ps
module sim_fine_pan_shifter;

    localparam int PW  = 8;
    localparam int WP  = 8;
    localparam int NWD = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_start = 1'b0;
    logic          line_start = 1'b0;
    logic          split_hit = 1'b0;
    logic          pan_split_mode = 1'b0;
    logic [1:0]    pel_mode = 2'b00;
    logic [3:0]    fine_cnt = 4'd0;
    logic [1:0]    coarse_pan = 2'd0;
    logic          word_vld = 1'b0;
    logic [WP*PW-1:0] word_data = '0;
    logic          pix_vld;
    logic [2*PW-1:0] pix;

    int n_vec = 0;
    int n_bad = 0;
    int cap_n = 0;
    logic [2*PW-1:0] cap [4];
    int vld_seen = 0;

    always #2.5 clk = ~clk;

    fine_pan_shifter #(.PIX_W(PW), .WORD_PIX(WP), .DEPTH(3)) u0 (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_start(line_start),
        .split_hit(split_hit), .pan_split_mode(pan_split_mode), .pel_mode(pel_mode),
        .fine_cnt(fine_cnt), .coarse_pan(coarse_pan), .word_vld(word_vld),
        .word_data(word_data), .pix_vld(pix_vld), .pix(pix)
    );

    always @(negedge clk) begin
        if (pix_vld) begin
            vld_seen = vld_seen + 1;
            if (cap_n < 4) begin
                cap[cap_n] = pix;
                cap_n = cap_n + 1;
            end
        end
    end

    task automatic check(input string req, input logic [2*PW-1:0] act, input logic [2*PW-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic pulse_frame();
        frame_start = 1'b1;
        tick();
        frame_start = 1'b0;
    endtask

    function automatic int fine_of(input logic [1:0] m, input logic [3:0] c);
        if (m == 2'b01) return (int'(c) + 1) % 9;
        if (m == 2'b10) return int'(c) & 6;
        return int'(c) & 7;
    endfunction

    task automatic run_line(input string req, input int exp_skip, input logic split_now);
        logic [3:0] keep_cnt;
        logic [1:0] keep_coarse;
        logic pair;
        keep_cnt = fine_cnt;
        keep_coarse = coarse_pan;
        pair = (pel_mode == 2'b10);
        line_start = 1'b1;
        split_hit = split_now;
        tick();
        cap_n = 0;
        line_start = 1'b0;
        split_hit = 1'b0;
        tick();
        fine_cnt = keep_cnt ^ 4'h5;      // R6 disturbance mid-line
        coarse_pan = keep_coarse ^ 2'd1;
        for (int j = 0; j < NWD; j++) begin
            for (int i = 0; i < WP; i++) word_data[i*PW +: PW] = PW'(j*WP + i);
            word_vld = 1'b1;
            tick();
            word_vld = 1'b0;
            for (int w = 0; w < (pair ? WP/2 : WP) - 1; w++) tick();
        end
        for (int w = 0; w < 40; w++) tick();
        fine_cnt = keep_cnt;
        coarse_pan = keep_coarse;
        for (int k = 0; k < 2; k++) begin
            logic [2*PW-1:0] e;
            int s;
            s = exp_skip + k*(pair ? 2 : 1);
            e = pair ? {PW'(s), PW'(s+1)} : {{PW{1'b0}}, PW'(s)};
            if (cap_n <= k) begin
                n_vec++;
                n_bad++;
                $display("FAIL %s missing pixel %0d actual=none expected=%h", req, k, e);
            end else begin
                check(req, cap[k], e);
            end
        end
    endtask

    initial begin
        #(150000*5);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        tick(); tick();
        check("R1 reset", {15'd0, pix_vld}, '0);
        rst_n = 1'b1;
        tick();
        // R1: words offered while idle must not produce output
        vld_seen = 0;
        for (int j = 0; j < 4; j++) begin
            word_vld = 1'b1; tick(); word_vld = 1'b0; tick();
        end
        for (int w = 0; w < 10; w++) tick();
        check("R1 idle words ignored", 16'(vld_seen), '0);

        // R2 R3 R4 R5 R9 sweep of modes, counts and coarse offsets
        for (int m = 0; m < 4; m++) begin
            for (int c = 0; c < 16; c++) begin
                for (int k = 0; k < 4; k++) begin
                    pel_mode = 2'(m);
                    fine_cnt = 4'(c);
                    coarse_pan = 2'(k);
                    run_line(m == 1 ? "R3" : (m == 2 ? "R4" : "R2"),
                             fine_of(2'(m), 4'(c)) + k*WP, 1'b0);
                end
            end
        end

        // R7: split with zeroing mode
        pel_mode = 2'b00; fine_cnt = 4'd5; coarse_pan = 2'd1;
        pan_split_mode = 1'b1;
        pulse_frame();
        run_line("R7 above split", 13, 1'b0);
        split_hit = 1'b1; tick(); split_hit = 1'b0;
        run_line("R7 below split", 0, 1'b0);
        run_line("R7 below split again", 0, 1'b0);
        pulse_frame();
        run_line("R7 new frame", 13, 1'b0);
        run_line("R7 split with line start", 0, 1'b1);
        pulse_frame();
        // R1: after frame start, no output until a line begins
        vld_seen = 0;
        for (int w = 0; w < 20; w++) tick();
        check("R1 after frame", 16'(vld_seen), '0);

        // R8: split ignored when mode bit clear
        pan_split_mode = 1'b0;
        pel_mode = 2'b01; fine_cnt = 4'd7; coarse_pan = 2'd2;
        run_line("R8 before split", 24, 1'b0);
        split_hit = 1'b1; tick(); split_hit = 1'b0;
        run_line("R8 after split", 24, 1'b0);
        run_line("R8 split with line start", 24, 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule